// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Edge and Level Interrupts

This block is a general-purpose I/O peripheral for sixteen pads. It sits behind a simple single-cycle register bus: an address, a write strobe, write data and registered read data. Software sets an output value and an output enable for each pin and reads back the synchronised pad inputs. The output, enable and interrupt-status registers each have a plain write address plus two alias addresses, one where 1 bits set and one where 1 bits clear. With these, one pin can be changed without a read-modify-write sequence.

Each pin has a small control word with four fields. A drive-mode bit chooses push-pull or open-drain drive. A 3-bit trigger code picks rising, falling, any-edge, low-level or high-level detection. A wake bit turns a level trigger into a wake-up request. A spare source bit is only stored.

Detected conditions latch into a sticky status register. One combined interrupt line is the OR of all status bits. A level trigger keeps re-asserting its status bit for as long as the level holds.

Top module: `gpio_ctrl`

## Requirements
- R1: After a synchronous reset, the output, enable and status registers and all control words are zero. The pad outputs, output enables, `irq` and `wake` are low, and every register reads 0.
- R2: Output register: a write to 0x00 loads it. At 0x04, each 1 bit sets the matching output bit. At 0x08, each 1 bit clears it. Zero bits in either alias leave the register unchanged.
- R3: Output-enable register: a write to 0x0C loads it, 0x10 sets bits and 0x14 clears bits, with the same bitwise rules as R2.
- R4: Address 0x18 reads the pad inputs after a two-flop synchroniser. A pad change becomes readable only from the third bus read issued after it. Writes to 0x18 have no effect.
- R5: In push-pull mode (control bit 2 = 0), `pad_out[n]` follows output bit n and `pad_oe[n]` follows enable bit n, one clock after the register changes. The output value can be written while the pin is an input.
- R6: In open-drain mode (control bit 2 = 1), `pad_out[n]` is 0. `pad_oe[n]` is high only when enable bit n is 1 and output bit n is 0, so a 1 in the output register releases the pad.
- R7: The control word of pin n lives at 0x28 + 4*n. Bit 0 is a stored source bit, bit 2 selects open-drain drive, bits 9:7 hold the trigger code and bit 10 is the wake enable. All other bits read back as 0, so writing 0xFFFFFFFF reads back 0x785.
- R8: Trigger code 001 sets the pin's status bit on a rising edge of the synchronised input, 010 on a falling edge and 011 on either edge.
- R9: Trigger code 100 sets the status bit every cycle the synchronised input is low, and 101 every cycle it is high. Codes 000, 110 and 111 never set status.
- R10: Status bits are sticky. A write to 0x1C loads the status register, 0x20 sets bits and 0x24 clears bits. A pin condition detected in the same cycle as a clear wins, so a held level re-asserts its bit at once.
- R11: `irq` is high exactly when at least one status bit is set. A status-set write alone raises it.
- R12: `wake` is high one clock after the synchronised input of any pin meets that pin's level trigger (code 100 or 101) while its wake bit is set. With an edge code, or with the wake bit clear, the pin never raises `wake`.
- R13: `bus_rdata` appears one clock after the address and shows register contents from before any write in that same cycle. The set and clear aliases read back their target register. Unmapped or misaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 16 | Asynchronous pad inputs |
| pad_out | output | 16 | Registered pad output values |
| pad_oe | output | 16 | Registered pad output enables |
| irq | output | 1 | Combined interrupt, OR of the status bits |
| wake | output | 1 | Registered wake-up request |

## Verification
Every result has a fixed delay. Read data and pad drive appear one clock after the bus cycle that causes them. A pad change reaches the input readback and the edge detectors two clocks later. Status, `irq` and `wake` update on the edge where the synchronised condition is first seen.

The bench steps a behavioural model on the same edges the design uses. It drives inputs and compares every output on the falling edge, so each compare lands after the producing edge and before the next. Directed reads check known values at these offsets, including the case where a clear and a held level meet in one cycle. A random phase then mixes all addresses with pad activity.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Register byte offsets
  localparam int OFS_OUT      = 'h00;
  localparam int OFS_OUT_SET  = 'h04;
  localparam int OFS_OUT_CLR  = 'h08;
  localparam int OFS_OE       = 'h0C;
  localparam int OFS_OE_SET   = 'h10;
  localparam int OFS_OE_CLR   = 'h14;
  localparam int OFS_IN       = 'h18;
  localparam int OFS_ST       = 'h1C;
  localparam int OFS_ST_SET   = 'h20;
  localparam int OFS_ST_CLR   = 'h24;
  localparam int CTRL_BASE    = 'h28;
  localparam int CTRL_STRIDE  = 4;

  // Control word bit positions
  localparam int CB_SRC     = 0;
  localparam int CB_OD      = 2;
  localparam int CB_TRIG_LO = 7;
  localparam int CB_WAKE    = 10;

  // Trigger codes
  localparam logic [2:0] TRIG_NONE = 3'b000;
  localparam logic [2:0] TRIG_RISE = 3'b001;
  localparam logic [2:0] TRIG_FALL = 3'b010;
  localparam logic [2:0] TRIG_ANY  = 3'b011;
  localparam logic [2:0] TRIG_LOW  = 3'b100;
  localparam logic [2:0] TRIG_HIGH = 3'b101;

  typedef struct packed {
    logic       wake;
    logic [2:0] trig;
    logic       od;
    logic       src;
  } pin_cfg_t;

  function automatic logic [31:0] cfg_to_word(pin_cfg_t c);
    logic [31:0] w;
    w                   = '0;
    w[CB_SRC]           = c.src;
    w[CB_OD]            = c.od;
    w[CB_TRIG_LO +: 3]  = c.trig;
    w[CB_WAKE]          = c.wake;
    return w;
  endfunction

endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_plain,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);

  logic [W-1:0] d;

  always_comb begin
    d = q;
    if (wr_plain)    d = wdata;
    else if (wr_set) d = q | wdata;
    else if (wr_clr) d = q & ~wdata;
    d = d | hw_set;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);

  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] chain [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) chain[k] <= '0;
    end else begin
      chain[0] <= din;
      for (int k = 1; k < DEPTH; k++) chain[k] <= chain[k-1];
    end
  end

  assign cur  = chain[STAGES-1];
  assign prev = chain[STAGES];

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_en,
  input  pin_cfg_t wr_cfg,
  input  logic     cur,
  input  logic     prev,
  output pin_cfg_t cfg,
  output logic     evt,
  output logic     wake_req
);

  logic level_hit;

  always_ff @(posedge clk) begin
    if (rst)        cfg <= '0;
    else if (wr_en) cfg <= wr_cfg;
  end

  always_comb begin
    evt       = 1'b0;
    level_hit = 1'b0;
    case (cfg.trig)
      TRIG_RISE: evt = cur & ~prev;
      TRIG_FALL: evt = ~cur & prev;
      TRIG_ANY:  evt = cur ^ prev;
      TRIG_LOW: begin
        level_hit = ~cur;
        evt       = ~cur;
      end
      TRIG_HIGH: begin
        level_hit = cur;
        evt       = cur;
      end
      default: evt = 1'b0;
    endcase
    wake_req = cfg.wake & level_hit;
  end

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS   = 16,
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int SYNC_FF = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq,
  output logic             wake
);

  localparam int IDXW     = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam int CTRL_END = CTRL_BASE + CTRL_STRIDE * NPINS;

  logic [NPINS-1:0] out_q, oe_q, st_q;
  logic [NPINS-1:0] in_cur, in_prev;
  logic [NPINS-1:0] evt_vec, wake_req_vec, od_vec, cfg_wr;
  pin_cfg_t         cfg [NPINS];
  pin_cfg_t         wr_cfg;
  logic             ctrl_hit;
  logic [IDXW-1:0]  ctrl_idx;
  logic [DW-1:0]    rd_nxt;

  function automatic logic hit(input logic [AW-1:0] a, input int ofs);
    return a == AW'(ofs);
  endfunction

  // Control word window decode
  assign ctrl_hit = (bus_addr >= AW'(CTRL_BASE)) && (bus_addr < AW'(CTRL_END))
                    && (bus_addr[1:0] == 2'b00);
  assign ctrl_idx = IDXW'((bus_addr - AW'(CTRL_BASE)) >> 2);

  always_comb begin
    wr_cfg      = '0;
    wr_cfg.src  = bus_wdata[CB_SRC];
    wr_cfg.od   = bus_wdata[CB_OD];
    wr_cfg.trig = bus_wdata[CB_TRIG_LO +: 3];
    wr_cfg.wake = bus_wdata[CB_WAKE];
  end

  // Input synchroniser and previous-sample stage
  gpio_sync #(.W(NPINS), .STAGES(SYNC_FF)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pad_in),
    .cur (in_cur),
    .prev(in_prev)
  );

  // Output, enable and status registers with aliases
  gpio_setclr_reg #(.W(NPINS)) u_out (
    .clk     (clk),
    .rst     (rst),
    .wr_plain(bus_we && hit(bus_addr, OFS_OUT)),
    .wr_set  (bus_we && hit(bus_addr, OFS_OUT_SET)),
    .wr_clr  (bus_we && hit(bus_addr, OFS_OUT_CLR)),
    .wdata   (bus_wdata[NPINS-1:0]),
    .hw_set  ({NPINS{1'b0}}),
    .q       (out_q)
  );

  gpio_setclr_reg #(.W(NPINS)) u_oe (
    .clk     (clk),
    .rst     (rst),
    .wr_plain(bus_we && hit(bus_addr, OFS_OE)),
    .wr_set  (bus_we && hit(bus_addr, OFS_OE_SET)),
    .wr_clr  (bus_we && hit(bus_addr, OFS_OE_CLR)),
    .wdata   (bus_wdata[NPINS-1:0]),
    .hw_set  ({NPINS{1'b0}}),
    .q       (oe_q)
  );

  gpio_setclr_reg #(.W(NPINS)) u_status (
    .clk     (clk),
    .rst     (rst),
    .wr_plain(bus_we && hit(bus_addr, OFS_ST)),
    .wr_set  (bus_we && hit(bus_addr, OFS_ST_SET)),
    .wr_clr  (bus_we && hit(bus_addr, OFS_ST_CLR)),
    .wdata   (bus_wdata[NPINS-1:0]),
    .hw_set  (evt_vec),
    .q       (st_q)
  );

  // Per-pin control, detection and pad drive
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign cfg_wr[i] = bus_we && ctrl_hit && (ctrl_idx == IDXW'(i));

    gpio_pin_ctrl u_ctl (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_wr[i]),
      .wr_cfg  (wr_cfg),
      .cur     (in_cur[i]),
      .prev    (in_prev[i]),
      .cfg     (cfg[i]),
      .evt     (evt_vec[i]),
      .wake_req(wake_req_vec[i])
    );

    assign od_vec[i] = cfg[i].od;

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
      end else if (od_vec[i]) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= oe_q[i] & ~out_q[i];
      end else begin
        pad_out[i] <= out_q[i];
        pad_oe[i]  <= oe_q[i];
      end
    end
  end

  // Read mux
  always_comb begin
    rd_nxt = '0;
    if (hit(bus_addr, OFS_OUT) || hit(bus_addr, OFS_OUT_SET) || hit(bus_addr, OFS_OUT_CLR))
      rd_nxt = DW'(out_q);
    else if (hit(bus_addr, OFS_OE) || hit(bus_addr, OFS_OE_SET) || hit(bus_addr, OFS_OE_CLR))
      rd_nxt = DW'(oe_q);
    else if (hit(bus_addr, OFS_IN))
      rd_nxt = DW'(in_cur);
    else if (hit(bus_addr, OFS_ST) || hit(bus_addr, OFS_ST_SET) || hit(bus_addr, OFS_ST_CLR))
      rd_nxt = DW'(st_q);
    else if (ctrl_hit)
      rd_nxt = DW'(cfg_to_word(cfg[ctrl_idx]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      wake      <= 1'b0;
    end else begin
      bus_rdata <= rd_nxt;
      wake      <= |wake_req_vec;
    end
  end

  assign irq = |st_q;

endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [NPINS-1:0] wdata,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic             irq,
  input logic             wake,
  input logic [NPINS-1:0] out_q,
  input logic [NPINS-1:0] oe_q,
  input logic [NPINS-1:0] st_q,
  input logic [NPINS-1:0] od_vec
);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_out == '0 && pad_oe == '0 && !wake));

  a_r2_set_alias_sets: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(OFS_OUT_SET)) |=> ((out_q & $past(wdata)) == $past(wdata)));

  a_r3_clr_alias_clears: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(OFS_OE_CLR)) |=> ((oe_q & $past(wdata)) == '0));

  a_r6_od_never_high: assert property (@(posedge clk) disable iff (rst)
    (($past(od_vec) & pad_out) == '0));

  a_r10_status_sticky: assert property (@(posedge clk) disable iff (rst)
    (($past(st_q) & ~st_q) != '0) |->
      ($past(bus_we) && ($past(bus_addr) == AW'(OFS_ST_CLR) || $past(bus_addr) == AW'(OFS_ST))));

  a_r11_irq_tracks_status: assert property (@(posedge clk) disable iff (rst)
    irq == (st_q != '0));

  a_r12_wake_with_status: assert property (@(posedge clk) disable iff (rst)
    wake |-> irq);

endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_we  (bus_we),
  .bus_addr(bus_addr),
  .wdata   (bus_wdata[NPINS-1:0]),
  .pad_out (pad_out),
  .pad_oe  (pad_oe),
  .irq     (irq),
  .wake    (wake),
  .out_q   (out_q),
  .oe_q    (oe_q),
  .st_q    (st_q),
  .od_vec  (od_vec)
);

// File: tb/test_gpio_ctrl.sv
module test_gpio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [15:0] pin_in = '0;
  logic [31:0] rdata;
  logic [15:0] pout, poe;
  logic        irq, wake;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ctrl i_gpio_ctrl (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wd),
    .bus_rdata(rdata), .pad_in(pin_in), .pad_out(pout), .pad_oe(poe),
    .irq(irq), .wake(wake)
  );

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_out, m_oe, m_st, m_s1, m_s2, m_s3, m_pout, m_poe;
  logic [31:0] m_cfg [NP];
  logic [31:0] m_rd;
  logic        m_irq, m_wake;
  bit          m_valid = 0;

  function automatic bit is_ctrl(input int a);
    return (a >= 'h28) && (a < 'h28 + 4*NP) && (a % 4 == 0);
  endfunction

  function automatic logic [31:0] model_read(input int a);
    case (a)
      'h00, 'h04, 'h08: return {16'h0, m_out};
      'h0C, 'h10, 'h14: return {16'h0, m_oe};
      'h18:             return {16'h0, m_s2};
      'h1C, 'h20, 'h24: return {16'h0, m_st};
      default:          return is_ctrl(a) ? m_cfg[(a - 'h28) / 4] : 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_out = '0; m_oe = '0; m_st = '0; m_s1 = '0; m_s2 = '0; m_s3 = '0;
      m_pout = '0; m_poe = '0; m_rd = '0; m_irq = 0; m_wake = 0;
      for (int i = 0; i < NP; i++) m_cfg[i] = '0;
      m_valid = 0;
    end else begin
      logic [15:0] ev;
      logic        wk;
      int          a;
      a = int'(addr);
      m_rd = model_read(a);
      ev = '0;
      wk = 0;
      for (int i = 0; i < NP; i++) begin
        int t;
        bit lvl;
        if (m_cfg[i][2]) begin
          m_pout[i] = 1'b0;
          m_poe[i]  = m_oe[i] & ~m_out[i];
        end else begin
          m_pout[i] = m_out[i];
          m_poe[i]  = m_oe[i];
        end
        t = int'((m_cfg[i] >> 7) & 7);
        lvl = (t == 4 && !m_s2[i]) || (t == 5 && m_s2[i]);
        if (t == 1) ev[i] = m_s2[i] && !m_s3[i];
        else if (t == 2) ev[i] = !m_s2[i] && m_s3[i];
        else if (t == 3) ev[i] = m_s2[i] != m_s3[i];
        else ev[i] = lvl;
        if (m_cfg[i][10] && lvl) wk = 1;
      end
      if (we) begin
        case (a)
          'h00: m_out = wd[15:0];
          'h04: m_out = m_out | wd[15:0];
          'h08: m_out = m_out & ~wd[15:0];
          'h0C: m_oe = wd[15:0];
          'h10: m_oe = m_oe | wd[15:0];
          'h14: m_oe = m_oe & ~wd[15:0];
          'h1C: m_st = wd[15:0];
          'h20: m_st = m_st | wd[15:0];
          'h24: m_st = m_st & ~wd[15:0];
          default: if (is_ctrl(a)) m_cfg[(a - 'h28) / 4] = wd & 32'h0000_0785;
        endcase
      end
      m_st   = m_st | ev;
      m_irq  = |m_st;
      m_wake = wk;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      m_valid = 1;
    end
  end

  // ---------------- checking ----------------
  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (m_valid) begin
      check(cur_tag, "bus_rdata", rdata, m_rd);
      check(cur_tag, "pad_out", {16'h0, pout}, {16'h0, m_pout});
      check(cur_tag, "pad_oe", {16'h0, poe}, {16'h0, m_poe});
      check(cur_tag, "irq", {31'h0, irq}, {31'h0, m_irq});
      check(cur_tag, "wake", {31'h0, wake}, {31'h0, m_wake});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wd = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); we = 1'b0; addr = 8'hFC; wd = '0;
    end
  endtask

  task automatic pads(input logic [15:0] v);
    @(negedge clk); we = 1'b0; addr = 8'hFC; pin_in = v;
  endtask

  task automatic rd_expect(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); we = 1'b0; addr = a; wd = '0;
    @(negedge clk); addr = 8'hFC;
    check(tag, "read", rdata, exp);
  endtask

  task automatic bit_expect(input string tag, input string what, input logic act,
                            input logic exp);
    check(tag, what, {31'h0, act}, {31'h0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    addr = 8'hFC;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    idle(2);

    cur_tag = "R1";
    rd_expect("R1", 8'h00, 32'h0);
    rd_expect("R1", 8'h1C, 32'h0);
    rd_expect("R1", 8'h28, 32'h0);
    bit_expect("R1", "irq", irq, 1'b0);

    cur_tag = "R2";
    wr(8'h00, 32'h0000_A5A5);
    wr(8'h04, 32'h0000_0F00);
    wr(8'h08, 32'h0000_0005);
    rd_expect("R2", 8'h00, 32'h0000_AFA0);
    rd_expect("R13", 8'h04, 32'h0000_AFA0);

    cur_tag = "R3";
    wr(8'h0C, 32'h0000_00FF);
    wr(8'h10, 32'h0000_0300);
    wr(8'h14, 32'h0000_0001);
    rd_expect("R3", 8'h0C, 32'h0000_03FE);

    cur_tag = "R5";
    idle(2);
    check("R5", "pad_out", {16'h0, pout}, 32'h0000_AFA0);
    check("R5", "pad_oe", {16'h0, poe}, 32'h0000_03FE);

    cur_tag = "R6";
    wr(8'h34, 32'h0000_0004);
    idle(2);
    bit_expect("R6", "pad_oe[3] drives low", poe[3], 1'b1);
    bit_expect("R6", "pad_out[3]", pout[3], 1'b0);
    wr(8'h04, 32'h0000_0008);
    idle(2);
    bit_expect("R6", "pad_oe[3] released", poe[3], 1'b0);
    bit_expect("R6", "pad_out[3]", pout[3], 1'b0);

    cur_tag = "R7";
    wr(8'h3C, 32'hFFFF_FFFF);
    rd_expect("R7", 8'h3C, 32'h0000_0785);
    wr(8'h64, 32'h0000_0381);
    rd_expect("R7", 8'h64, 32'h0000_0381);

    cur_tag = "R13";
    rd_expect("R13", 8'h68, 32'h0);
    rd_expect("R13", 8'h2A, 32'h0);

    cur_tag = "R4";
    wr(8'h18, 32'h0000_FFFF);
    pads(16'h1234);
    idle(3);
    rd_expect("R4", 8'h18, 32'h0000_1234);
    pads(16'h8F0F);
    rd_expect("R4", 8'h18, 32'h0000_1234);
    idle(2);
    rd_expect("R4", 8'h18, 32'h0000_8F0F);
    rd_expect("R9", 8'h1C, 32'h0);

    cur_tag = "R8";
    pads(16'h0000);
    idle(4);
    wr(8'h28, 32'h0000_0080);
    wr(8'h2C, 32'h0000_0100);
    wr(8'h30, 32'h0000_0180);
    wr(8'h1C, 32'h0);
    pads(16'h0001);
    idle(4);
    rd_expect("R8", 8'h1C, 32'h0000_0001);
    pads(16'h0007);
    idle(4);
    rd_expect("R8", 8'h1C, 32'h0000_0005);
    pads(16'h0000);
    idle(4);
    rd_expect("R8", 8'h1C, 32'h0000_0007);
    wr(8'h24, 32'h0000_0007);
    rd_expect("R10", 8'h1C, 32'h0);

    cur_tag = "R9";
    wr(8'h38, 32'h0000_0200);
    idle(2);
    rd_expect("R9", 8'h1C, 32'h0000_0010);
    wr(8'h24, 32'h0000_0010);
    rd_expect("R10", 8'h1C, 32'h0000_0010);
    pads(16'h8010);
    idle(4);
    wr(8'h24, 32'h0000_0010);
    rd_expect("R9", 8'h1C, 32'h0);
    wr(8'h40, 32'h0000_0280);
    pads(16'h0050);
    idle(4);
    rd_expect("R9", 8'h1C, 32'h0000_0040);
    pads(16'h0010);
    idle(4);
    wr(8'h24, 32'h0000_0040);
    rd_expect("R9", 8'h1C, 32'h0);

    cur_tag = "R11";
    wr(8'h20, 32'h0000_8000);
    idle(1);
    bit_expect("R11", "irq after set alias", irq, 1'b1);
    rd_expect("R10", 8'h1C, 32'h0000_8000);
    wr(8'h1C, 32'h0);
    idle(1);
    bit_expect("R11", "irq after plain clear", irq, 1'b0);

    cur_tag = "R12";
    wr(8'h44, 32'h0000_0680);
    pads(16'h0090);
    idle(4);
    bit_expect("R12", "wake level+enable", wake, 1'b1);
    wr(8'h44, 32'h0000_0280);
    idle(2);
    bit_expect("R12", "wake enable clear", wake, 1'b0);
    wr(8'h44, 32'h0000_0480);
    idle(2);
    bit_expect("R12", "wake with edge code", wake, 1'b0);

    cur_tag = "R10";
    for (int k = 0; k < 400; k++) begin
      int r;
      logic [7:0] a;
      r = int'($urandom % 13);
      case (r)
        0: a = 8'h00;  1: a = 8'h04;  2: a = 8'h08;  3: a = 8'h0C;
        4: a = 8'h10;  5: a = 8'h14;  6: a = 8'h18;  7: a = 8'h1C;
        8: a = 8'h20;  9: a = 8'h24;  10: a = 8'h68;
        default: a = 8'(8'h28 + 4 * ($urandom % 16));
      endcase
      @(negedge clk);
      we = $urandom % 2;
      addr = a;
      wd = $urandom;
      if ($urandom % 4 == 0) pin_in = 16'($urandom);
    end
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule